// File: doc/BRIEF.md
# Diagnostic Frame Serializer

This block sends a 30-byte diagnostic frame on a two-wire serial link made of a clock line and a data line. A one-cycle trigger starts a frame. The block captures a parallel snapshot of the sensing state in the same cycle that it starts. The snapshot holds four baselines, four raw readings, four signed differences, two flag bytes, a calibration bit, an active-key count and four touch bits. While no frame is in flight, both lines are released: their output enables are low, so an external pad can float them. During a frame both lines are driven push-pull.

The shape of each bit is set by `HALF_BIT` system clocks per clock phase. The pause between bytes is set by `GAP_CYC` clocks. With a 50 MHz system clock, the defaults give a 200 kHz bit clock and about 50 µs from the start of one byte to the start of the next. An internal 8-bit frame number leads every frame and closes it. The number advances once per completed frame.

Top module: `dbg_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight, both output enables are low, the clock and data outputs are both 0, and the frame number is 0 until the first frame completes.
- R2: A trigger sampled high while idle starts a frame in the next cycle. Both enables then stay high for exactly 480·HALF_BIT + 29·GAP_CYC cycles, during which exactly 30 bytes are sent. After that, both enables drop together.
- R3: Each byte is sent most significant bit first. A bit is HALF_BIT cycles with the clock low followed by HALF_BIT cycles with the clock high. Data changes only while the clock is low and is held stable while the clock is high, so the receiver samples on the rising edge.
- R4: Byte 0 is the frame number. Byte 1 is the version: VER_MAJOR in bits 7:4 and VER_MINOR in bits 3:0. Bytes 2–9 are baselines 0–3, bytes 10–17 are readings 0–3 and bytes 18–25 are differences 0–3. Each 16-bit value is sent low byte first. Key k occupies bits 16k+15:16k of its input bus.
- R5: Byte 26 is `flag0_i` and byte 27 is `flag1_i`. Byte 28 is the status byte: bit 7 is `cal_i`, bits 6:4 are `key_cnt_i`, and bits 3:0 are `touch_i` (bit n for key n).
- R6: Byte 29 repeats byte 0. The frame number increments by one at the end of each frame and wraps from 255 to 0.
- R7: All inputs are captured in the cycle the frame starts. Input changes during a frame do not alter that frame.
- R8: A trigger that arrives while a frame is in flight is ignored and is not queued. This includes the frame's final cycle. With the trigger held high, successive frames are separated by exactly one released cycle.
- R9: The first rising clock edges of consecutive bytes are 16·HALF_BIT + GAP_CYC cycles apart. During the gap the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| send_i | input | 1 | Frame trigger, sampled while idle |
| cal_i | input | 1 | Calibration-in-progress bit for the status byte |
| key_cnt_i | input | 3 | Active key count for the status byte |
| touch_i | input | 4 | Per-key touch state for the status byte |
| ref_i | input | 64 | Four 16-bit baselines |
| sig_i | input | 64 | Four 16-bit raw readings |
| delta_i | input | 64 | Four signed 16-bit differences |
| flag0_i | input | 8 | First flag byte |
| flag1_i | input | 8 | Second flag byte |
| sclk_o | output | 1 | Serial clock, low while released |
| sclk_oe_o | output | 1 | Output enable for the clock line |
| sdat_o | output | 1 | Serial data |
| sdat_oe_o | output | 1 | Output enable for the data line |

## Verification
The end of a frame and the acceptance of a new trigger can land in adjacent cycles. In that window, the release of the lines, the frame-number increment and a waiting trigger all interact. The bench holds the trigger high across 257 consecutive frames, enough to wrap the frame number. It requires exactly one released cycle between frames and consecutive frame numbers in bytes 0 and 29. It also pulses the trigger in the middle of a frame and checks that no extra frame follows. The inputs are reshuffled at every frame start, so each decoded frame must match the values captured at its own start.

// File: rtl/dbg_tx_pkg.sv
package dbg_tx_pkg;
  localparam int NKEYS       = 4;
  localparam int WORD_W      = 16;
  localparam int FRAME_BYTES = 30;
  localparam int IDX_W       = $clog2(FRAME_BYTES + 1);

  typedef struct packed {
    logic [7:0]                    ver;
    logic [NKEYS-1:0][WORD_W-1:0]  refs;
    logic [NKEYS-1:0][WORD_W-1:0]  sigs;
    logic [NKEYS-1:0][WORD_W-1:0]  dlts;
    logic [7:0]                    flg0;
    logic [7:0]                    flg1;
    logic [7:0]                    stat;
  } snap_t;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_GAP} tx_st_t;
endpackage

// File: rtl/dbg_half_tick.sv
module dbg_half_tick #(
  parameter int HALF_BIT = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (HALF_BIT <= 1) begin : g_fast
      assign tick_o = run_i;
    end else begin : g_cnt
      localparam int CW = $clog2(HALF_BIT);
      logic [CW-1:0] cnt;
      assign tick_o = run_i && (cnt == CW'(HALF_BIT - 1));
      always_ff @(posedge clk) begin
        if (rst || !run_i) cnt <= '0;
        else if (tick_o)   cnt <= '0;
        else               cnt <= cnt + 1'b1;
      end
      // R3: phase counter never passes one half bit
      p_tick_bound_r3: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < HALF_BIT);
    end
  endgenerate
endmodule

// File: rtl/dbg_byte_sel.sv
module dbg_byte_sel
  import dbg_tx_pkg::*;
(
  input  snap_t             snap,
  input  logic [7:0]        frame_no,
  input  logic [IDX_W-1:0]  idx,
  output logic [7:0]        byte_o
);
  logic [IDX_W-1:0]  off;
  logic [WORD_W-1:0] word;

  always_comb begin
    off    = idx - IDX_W'(2);
    word   = '0;
    byte_o = '0;
    if (idx == '0)      byte_o = frame_no;
    else if (idx == IDX_W'(1)) byte_o = snap.ver;
    else begin
      case (off[4:3])
        2'd0:    word = snap.refs[off[2:1]];
        2'd1:    word = snap.sigs[off[2:1]];
        2'd2:    word = snap.dlts[off[2:1]];
        default: word = '0;
      endcase
      if (off[4:3] != 2'd3) byte_o = off[0] ? word[15:8] : word[7:0];
      else begin
        case (off[2:0])
          3'd0:    byte_o = snap.flg0;
          3'd1:    byte_o = snap.flg1;
          3'd2:    byte_o = snap.stat;
          default: byte_o = frame_no;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_frame_tx.sv
module dbg_frame_tx
  import dbg_tx_pkg::*;
#(
  parameter int HALF_BIT  = 125,
  parameter int GAP_CYC   = 500,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    send_i,
  input  logic                    cal_i,
  input  logic [2:0]              key_cnt_i,
  input  logic [NKEYS-1:0]        touch_i,
  input  logic [NKEYS*WORD_W-1:0] ref_i,
  input  logic [NKEYS*WORD_W-1:0] sig_i,
  input  logic [NKEYS*WORD_W-1:0] delta_i,
  input  logic [7:0]              flag0_i,
  input  logic [7:0]              flag1_i,
  output logic                    sclk_o,
  output logic                    sclk_oe_o,
  output logic                    sdat_o,
  output logic                    sdat_oe_o
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BYTES - 1);

  tx_st_t           st;
  snap_t            snap_d, snap_q;
  logic [7:0]       frame_cnt, sh, next_byte;
  logic [IDX_W-1:0] byte_idx;
  logic [2:0]       bit_idx;
  logic [GW-1:0]    gap_cnt;
  logic             sclk_q, oe_q, tick;

  always_comb begin
    snap_d      = '0;
    snap_d.ver  = {4'(VER_MAJOR), 4'(VER_MINOR)};
    snap_d.refs = ref_i;
    snap_d.sigs = sig_i;
    snap_d.dlts = delta_i;
    snap_d.flg0 = flag0_i;
    snap_d.flg1 = flag1_i;
    snap_d.stat = {cal_i, key_cnt_i, touch_i};
  end

  dbg_half_tick #(.HALF_BIT(HALF_BIT)) u_tick (
    .clk(clk), .rst(rst), .run_i(st == S_LO || st == S_HI), .tick_o(tick));

  dbg_byte_sel u_sel (
    .snap(snap_q), .frame_no(frame_cnt), .idx(byte_idx + 1'b1), .byte_o(next_byte));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; snap_q <= '0; frame_cnt <= '0; sh <= '0;
      byte_idx <= '0; bit_idx <= '0; gap_cnt <= '0; sclk_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (send_i) begin
          snap_q   <= snap_d;
          sh       <= frame_cnt;
          oe_q     <= 1'b1;
          byte_idx <= '0;
          bit_idx  <= 3'd7;
          st       <= S_LO;
        end
        S_LO: if (tick) begin
          sclk_q <= 1'b1;
          st     <= S_HI;
        end
        S_HI: if (tick) begin
          sclk_q <= 1'b0;
          if (bit_idx != 3'd0) begin
            sh      <= {sh[6:0], 1'b0};
            bit_idx <= bit_idx - 3'd1;
            st      <= S_LO;
          end else if (byte_idx == LAST) begin
            st        <= S_IDLE;
            oe_q      <= 1'b0;
            sh        <= '0;
            frame_cnt <= frame_cnt + 8'd1;
          end else begin
            gap_cnt <= '0;
            st      <= S_GAP;
          end
        end
        default: begin
          if (gap_cnt == GW'(GAP_CYC - 1)) begin
            sh       <= next_byte;
            byte_idx <= byte_idx + 1'b1;
            bit_idx  <= 3'd7;
            st       <= S_LO;
          end else gap_cnt <= gap_cnt + 1'b1;
        end
      endcase
    end
  end

  assign sclk_o    = sclk_q;
  assign sdat_o    = sh[7];
  assign sclk_oe_o = oe_q;
  assign sdat_oe_o = oe_q;

  // R1: released lines are quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !sclk_oe_o |-> (!sclk_o && !sdat_o));
  // R3: data held through a high clock phase
  p_hold_high_r3: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdat_o));
  // R3: a data change while driven happens with the clock low
  p_change_low_r3: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe_o && !$stable(sdat_o)) |-> !sclk_o);
  // R6: frame number steps by one at each release
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_oe_o) |-> (frame_cnt == $past(frame_cnt) + 8'd1));
  // R8: a trigger in flight leaves the snapshot alone
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && send_i) |=> $stable(snap_q));
  // R4: byte index stays inside the frame
  p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
    32'(byte_idx) < FRAME_BYTES);
endmodule

// File: tb/dbg_frame_tx_test.sv
module dbg_frame_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 1;
  localparam int G = 2;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0, rst = 1'b1, send = 1'b0;
  logic cal = 1'b0;
  logic [2:0] kcnt = '0;
  logic [3:0] tch = '0;
  logic [63:0] refv = '0, sigv = '0, dltv = '0;
  logic [7:0] f0 = '0, f1 = '0;
  logic sclk_o, sclk_oe_o, sdat_o, sdat_oe_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_frame_tx #(.HALF_BIT(H), .GAP_CYC(G), .VER_MAJOR(2), .VER_MINOR(5)) uut (
    .clk(clk), .rst(rst), .send_i(send), .cal_i(cal), .key_cnt_i(kcnt), .touch_i(tch),
    .ref_i(refv), .sig_i(sigv), .delta_i(dltv), .flag0_i(f0), .flag1_i(f1),
    .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o), .sdat_o(sdat_o), .sdat_oe_o(sdat_oe_o));

  int vecs = 0, fails = 0, cyc_all = 0, cyc = 0;
  bit wd = 1'b0;
  always @(posedge clk) begin
    cyc_all <= cyc_all + 1;
    if (cyc_all > WD_LIMIT) wd <= 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected snapshot captured at each frame start
  logic [63:0] e_ref, e_sig, e_dlt;
  logic [7:0]  e_f0, e_f1, exp_fr = 8'd0;
  logic        e_cal;
  logic [2:0]  e_kc;
  logic [3:0]  e_tch;
  logic [31:0] rs = 32'h1f2e3d4c;

  function automatic logic [7:0] exp_byte(input int i);
    logic [15:0] w;
    int k;
    if (i == 0 || i == 29) return exp_fr;
    if (i == 1) return 8'h25;
    if (i == 26) return e_f0;
    if (i == 27) return e_f1;
    if (i == 28) return {e_cal, e_kc, e_tch};
    k = ((i - 2) % 8) / 2;
    if (i < 10)      w = e_ref[k*16 +: 16];
    else if (i < 18) w = e_sig[k*16 +: 16];
    else             w = e_dlt[k*16 +: 16];
    return ((i - 2) % 2 == 1) ? w[15:8] : w[7:0];
  endfunction

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  bit mutate = 1'b0, b2b = 1'b0, b2b_armed = 1'b0;
  int frames_done = 0, nbits = 0, nbytes = 0, drv_len = 0, hi_len = 0, idle_len = 0, last_rise = 0;
  logic oe_q = 1'b0, sclk_q = 1'b0, sdat_q = 1'b0;
  logic [7:0] cur = '0;
  logic [7:0] rx [30];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sclk_oe_o && !oe_q) begin
        if (b2b_armed) chk(idle_len == 1, "R8 released cycles between held-trigger frames", idle_len, 1);
        if (b2b) b2b_armed = 1'b1;
        nbits = 0; nbytes = 0; drv_len = 0; hi_len = 0;
        e_ref = refv; e_sig = sigv; e_dlt = dltv; e_f0 = f0; e_f1 = f1;
        e_cal = cal; e_kc = kcnt; e_tch = tch;
        if (mutate) begin // R7: inputs change right after capture
          rs = xs(rs); refv[31:0] = rs; rs = xs(rs); refv[63:32] = rs;
          rs = xs(rs); sigv[31:0] = rs; rs = xs(rs); sigv[63:32] = rs;
          rs = xs(rs); dltv[31:0] = rs; rs = xs(rs); dltv[63:32] = rs;
          rs = xs(rs); f0 = rs[7:0]; f1 = rs[15:8]; cal = rs[16]; kcnt = rs[19:17]; tch = rs[23:20];
        end
      end
      if (sclk_oe_o) begin
        drv_len++;
        chk(sdat_oe_o, "R2 data enable follows clock enable", sdat_oe_o, 1);
        if (sclk_o && sclk_q) chk(sdat_o == sdat_q, "R3 data stable while clock high", sdat_o, sdat_q);
        if (sclk_o) hi_len++;
        if (!sclk_o && sclk_q) begin
          chk(hi_len == H, "R3 high phase length", hi_len, H);
          hi_len = 0;
        end
        if (sclk_o && !sclk_q) begin
          if (nbits % 8 == 0) begin
            if (nbytes > 0) chk(cyc - last_rise == 16*H + G, "R9 byte start spacing", cyc - last_rise, 16*H + G);
            last_rise = cyc;
          end
          cur = {cur[6:0], sdat_o};
          nbits++;
          if (nbits % 8 == 0) begin
            if (nbytes < 30) rx[nbytes] = cur;
            nbytes++;
          end
        end
      end
      if (!sclk_oe_o && oe_q) begin
        chk(drv_len == 480*H + 29*G, "R2 driven length", drv_len, 480*H + 29*G);
        chk(nbytes == 30, "R2 bytes per frame", nbytes, 30);
        for (int i = 0; i < 30; i++) begin
          string tg;
          tg = (i == 0 || i == 29) ? "R6 frame number" : (i >= 26) ? "R5 flag/status" : "R4 field";
          if (mutate) tg = {tg, " R7"};
          chk(rx[i] == exp_byte(i), $sformatf("%s byte %0d frame %0d", tg, i, frames_done), rx[i], exp_byte(i));
        end
        exp_fr = exp_fr + 8'd1;
        frames_done++;
        idle_len = 0;
      end
      if (!sclk_oe_o) begin
        idle_len++;
        chk(!sclk_o && !sdat_o, "R1 lines low while released", {sclk_o, sdat_o}, 0);
      end
    end
    oe_q = sclk_oe_o; sclk_q = sclk_o; sdat_q = sdat_o;
  end

  initial begin
    refv = 64'h1234_5678_9abc_def0; sigv = 64'h0f1e_2d3c_4b5a_6978;
    dltv = 64'hfffe_8001_7fff_0003; f0 = 8'ha5; f1 = 8'h3c;
    cal = 1'b1; kcnt = 3'd4; tch = 4'b1010;
    repeat (5) @(negedge clk);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sclk_oe_o && !sdat_oe_o && !sclk_o && !sdat_o, "R1 reset state",
        {sclk_oe_o, sdat_oe_o, sclk_o, sdat_o}, 0);
    // single frame plus a stray trigger in the middle (R8)
    #1 send = 1'b1;
    @(negedge clk); #1 send = 1'b0;
    repeat (100) @(negedge clk);
    #1 send = 1'b1;
    @(negedge clk); #1 send = 1'b0;
    while (frames_done < 1 && !wd) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(frames_done == 1 && !sclk_oe_o, "R8 trigger during frame not queued", frames_done, 1);
    // held trigger: back-to-back frames across the 255 to 0 wrap (R6, R7, R8)
    #1 mutate = 1'b1; b2b = 1'b1; send = 1'b1;
    while (frames_done < 258 && !wd) begin @(negedge clk); #1; end
    send = 1'b0; b2b = 1'b0; b2b_armed = 1'b0; mutate = 1'b0;
    repeat (20) @(negedge clk);
    chk(!sclk_oe_o, "R1 released after last frame", sclk_oe_o, 0);
    chk(frames_done == 258, "R6 frames completed across wrap", frames_done, 258);
    chk(exp_fr == 8'd2, "R6 frame number after wrap", exp_fr, 2);
    if (wd) begin
      vecs++; fails++;
      $display("FAIL watchdog R2: actual %0d expected below %0d", cyc_all, WD_LIMIT);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule